// File: doc/BRIEF.md
# Data Breakpoint Value-Compare Unit

This unit sits beside the load/store path of a pipelined core. It watches every data access and raises a debug-break request when the access hits a programmed address and, if asked, carries a programmed data value. Each breakpoint slot has an address, an address mask (a 1 bit means "don't care"), a reference value, per-byte-lane ignore bits, and separate enables for loads and for stores. A slot whose lanes are all ignored matches on address alone.

Stores and address-only matches are resolved in the access cycle. A load that needs a value compare is parked in a small table indexed by the load's identifier. The compare takes place when the data returns, and only if the return carries no error. An error that arrives after a load has already broken does not cancel the break: it sets a bus-error or cache-error pending flag that the debug handler reads. Each break carries a tag that says whether the reported instruction is the access itself (precise) or a later one (imprecise). A load compare is imprecise when the load is non-blocking or when its address falls in a configured window. Such a window protects loads with side effects from being re-executed.

Top module: `dbv_unit`

## Requirements
- R1: An access hits a slot when the bits of its address not masked by the slot's mask (1 = ignore) equal the slot's address. A slot with all lanes ignored and the access type enabled then sets its status bit at the next clock edge and raises a precise break request (brk_imprecise = 0).
- R2: For a store that hits a slot with value compare active, every active byte lane whose ignore bit is 0 must equal the matching byte of the reference value. Otherwise no status bit is set and no break is raised. Lane k covers data bits [8k+7:8k].
- R3: A store flagged unaligned never produces a value-compare match. It can still match a slot whose lanes are all ignored.
- R4: A load that hits a value-compare slot produces nothing at the access. The compare is made when data returns with the same identifier. A match sets the status bit and raises a break at the edge that samples the return.
- R5: A return flagged with an error produces no status bit and no break, and it discards the pending compare. A later return for that identifier has no effect.
- R6: A late error for an identifier whose load has already broken sets pend_bus_err (lerr_cache = 0) or pend_cache_err (lerr_cache = 1). It leaves the status bits and the break alone. A late error for an identifier whose compare is still pending discards the compare, and no flag is set.
- R7: Status bits are set at detection even while brk_hold is 1. brk_req stays 0 while held and goes to 1 as soon as brk_hold drops.
- R8: A value-compare load match is imprecise (brk_imprecise = 1) when the load was non-blocking, or when the window is enabled and the load address matches the window base under the window mask. Otherwise it is precise.
- R9: Status bits and pending flags are sticky. They clear only through a configuration write of 1 to the bit: selector 7 for status (bit i = slot i), selector 8 for flags (bit 0 = bus, bit 1 = cache).
- R10: When several slots match in the same cycle, all of their status bits are set and a single one-cycle break request is raised.
- R11: A slot whose enable for the access type is 0 never matches. CTL layout: bit 0 = load enable, bit 1 = store enable, bits [2+NB-1:2] = lane ignore. The other selectors are 0 address, 1 address mask, 2 value, 4 window base, 5 window mask, and 6 window enable (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bp | input | $clog2(NUM_BP) | Slot selected by the write |
| cfg_sel | input | 4 | Field selector |
| cfg_wdata | input | DW | Write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_unaligned | input | 1 | Store to an unaligned address |
| acc_nonblk | input | 1 | Load is non-blocking |
| acc_addr | input | AW | Access address |
| acc_lanes | input | DW/8 | Active byte lanes |
| acc_wdata | input | DW | Store data |
| acc_id | input | IDW | Load identifier |
| rtn_valid | input | 1 | Load data returning |
| rtn_id | input | IDW | Identifier of returning load |
| rtn_data | input | DW | Returned data |
| rtn_err | input | 1 | Error reported with the data |
| lerr_valid | input | 1 | Late error indication |
| lerr_id | input | IDW | Identifier of the late error |
| lerr_cache | input | 1 | 1 = cache error, 0 = bus error |
| brk_hold | input | 1 | Pipeline cannot take the break yet |
| bp_status | output | NUM_BP | Sticky per-slot match bits |
| brk_req | output | 1 | Debug-break request |
| brk_imprecise | output | 1 | Break tag: 1 = imprecise |
| pend_bus_err | output | 1 | Late bus error after a break |
| pend_cache_err | output | 1 | Late cache error after a break |

## Verification
The bench builds the unit with two slots, 16-bit addresses and data (two byte lanes) and a four-entry identifier table. With two lanes, every combination of active lanes, ignore bits and differing bytes is small enough to sweep: 64 store vectors, plus the unaligned cases. The narrow address lets the bench walk a 32-address span around the mask boundary. Two slots are enough to exercise simultaneous matches and per-bit clears, and four identifiers let load, return and late-error orderings interleave.

// File: rtl/dbv_pkg.sv
package dbv_pkg;

    typedef enum logic [3:0] {
        SEL_ADDR   = 4'd0,
        SEL_AMASK  = 4'd1,
        SEL_VALUE  = 4'd2,
        SEL_CTL    = 4'd3,
        SEL_WBASE  = 4'd4,
        SEL_WMASK  = 4'd5,
        SEL_WEN    = 4'd6,
        SEL_STATUS = 4'd7,
        SEL_FLAGS  = 4'd8
    } cfg_sel_e;

    localparam int CTL_LD  = 0;
    localparam int CTL_ST  = 1;
    localparam int CTL_IGN = 2;

    localparam int FLG_BUS   = 0;
    localparam int FLG_CACHE = 1;

    // Address compare: bits set in ign are don't-care.
    function automatic logic masked_eq(input logic [63:0] a, input logic [63:0] b,
                                       input logic [63:0] ign);
        return ((a ^ b) & ~ign) == 64'd0;
    endfunction

endpackage

// File: rtl/dbv_match.sv
module dbv_match #(
    parameter  int DW = 32,
    localparam int NB = DW / 8
) (
    input  logic [NB-1:0] lanes,
    input  logic [NB-1:0] lane_ign,
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] ref_value,
    output logic          val_eq
);
    logic [NB-1:0] lane_ok;

    for (genvar k = 0; k < NB; k++) begin : g_lane
        assign lane_ok[k] = !(lanes[k] && !lane_ign[k]) ||
                            (data[8*k +: 8] == ref_value[8*k +: 8]);
    end

    assign val_eq = &lane_ok;
endmodule

// File: rtl/dbv_tag_table.sv
module dbv_tag_table #(
    parameter  int NUM_BP = 4,
    parameter  int NB     = 4,
    parameter  int IDW    = 3,
    localparam int DEPTH  = 1 << IDW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_en,
    input  logic [IDW-1:0]    alloc_id,
    input  logic [NUM_BP-1:0] alloc_bps,
    input  logic [NB-1:0]     alloc_lanes,
    input  logic              alloc_imp,
    input  logic [IDW-1:0]    look_id,
    output logic              look_valid,
    output logic [NUM_BP-1:0] look_bps,
    output logic [NB-1:0]     look_lanes,
    output logic              look_imp,
    input  logic              consume_en,
    input  logic              hit_en,
    input  logic              err_en,
    input  logic [IDW-1:0]    err_id,
    output logic              err_broke
);
    logic [DEPTH-1:0]  valid_q;
    logic [DEPTH-1:0]  broke_q;
    logic [DEPTH-1:0]  imp_q;
    logic [NUM_BP-1:0] bps_q   [DEPTH];
    logic [NB-1:0]     lanes_q [DEPTH];

    assign look_valid = valid_q[look_id];
    assign look_bps   = bps_q[look_id];
    assign look_lanes = lanes_q[look_id];
    assign look_imp   = imp_q[look_id];
    assign err_broke  = broke_q[err_id] && !valid_q[err_id];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            broke_q <= '0;
        end else begin
            if (consume_en) valid_q[look_id] <= 1'b0;
            if (hit_en)     broke_q[look_id] <= 1'b1;
            if (err_en) begin
                valid_q[err_id] <= 1'b0;
                broke_q[err_id] <= 1'b0;
            end
            if (alloc_en) begin
                valid_q[alloc_id] <= |alloc_bps;
                broke_q[alloc_id] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) begin
            bps_q[alloc_id]   <= alloc_bps;
            lanes_q[alloc_id] <= alloc_lanes;
            imp_q[alloc_id]   <= alloc_imp;
        end
    end

    assert_late_error_drops_R6: assert property (@(posedge clk) disable iff (rst)
        (err_en && !alloc_en) |=> !valid_q[$past(err_id)]);

    assert_load_armed_R4: assert property (@(posedge clk) disable iff (rst)
        (alloc_en && |alloc_bps) |=> valid_q[$past(alloc_id)]);
endmodule

// File: rtl/dbv_unit.sv
module dbv_unit
    import dbv_pkg::*;
#(
    parameter  int NUM_BP = 4,
    parameter  int AW     = 32,
    parameter  int DW     = 32,
    parameter  int IDW    = 3,
    localparam int NB     = DW / 8,
    localparam int BPW    = $clog2(NUM_BP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [BPW-1:0]    cfg_bp,
    input  logic [3:0]        cfg_sel,
    input  logic [DW-1:0]     cfg_wdata,
    input  logic              acc_valid,
    input  logic              acc_store,
    input  logic              acc_unaligned,
    input  logic              acc_nonblk,
    input  logic [AW-1:0]     acc_addr,
    input  logic [NB-1:0]     acc_lanes,
    input  logic [DW-1:0]     acc_wdata,
    input  logic [IDW-1:0]    acc_id,
    input  logic              rtn_valid,
    input  logic [IDW-1:0]    rtn_id,
    input  logic [DW-1:0]     rtn_data,
    input  logic              rtn_err,
    input  logic              lerr_valid,
    input  logic [IDW-1:0]    lerr_id,
    input  logic              lerr_cache,
    input  logic              brk_hold,
    output logic [NUM_BP-1:0] bp_status,
    output logic              brk_req,
    output logic              brk_imprecise,
    output logic              pend_bus_err,
    output logic              pend_cache_err
);
    cfg_sel_e sel;
    assign sel = cfg_sel_e'(cfg_sel);

    logic [AW-1:0]     bp_addr_q  [NUM_BP];
    logic [AW-1:0]     bp_amask_q [NUM_BP];
    logic [DW-1:0]     bp_value_q [NUM_BP];
    logic [NB-1:0]     bp_ign_q   [NUM_BP];
    logic [NUM_BP-1:0] ld_en_q, st_en_q;
    logic [AW-1:0]     win_base_q, win_mask_q;
    logic              win_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BP; i++) begin
                bp_addr_q[i]  <= '0;
                bp_amask_q[i] <= '0;
                bp_value_q[i] <= '0;
                bp_ign_q[i]   <= '1;
            end
            ld_en_q    <= '0;
            st_en_q    <= '0;
            win_base_q <= '0;
            win_mask_q <= '0;
            win_en_q   <= 1'b0;
        end else if (cfg_we) begin
            unique case (sel)
                SEL_ADDR:  bp_addr_q[cfg_bp]  <= AW'(cfg_wdata);
                SEL_AMASK: bp_amask_q[cfg_bp] <= AW'(cfg_wdata);
                SEL_VALUE: bp_value_q[cfg_bp] <= cfg_wdata;
                SEL_CTL: begin
                    ld_en_q[cfg_bp]  <= cfg_wdata[CTL_LD];
                    st_en_q[cfg_bp]  <= cfg_wdata[CTL_ST];
                    bp_ign_q[cfg_bp] <= cfg_wdata[CTL_IGN +: NB];
                end
                SEL_WBASE: win_base_q <= AW'(cfg_wdata);
                SEL_WMASK: win_mask_q <= AW'(cfg_wdata);
                SEL_WEN:   win_en_q   <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

    // Pending-load table
    logic              look_valid, look_imp, err_broke;
    logic [NUM_BP-1:0] look_bps;
    logic [NB-1:0]     look_lanes;
    logic [NUM_BP-1:0] imm_hit, arm, rtn_match;
    logic              in_window;

    assign in_window = win_en_q &&
        masked_eq(64'(acc_addr), 64'(win_base_q), 64'(win_mask_q));

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        logic a_hit, v_on, acc_eq, rtn_eq;

        dbv_match #(.DW(DW)) u_acc_cmp (
            .lanes(acc_lanes), .lane_ign(bp_ign_q[i]), .data(acc_wdata),
            .ref_value(bp_value_q[i]), .val_eq(acc_eq));

        dbv_match #(.DW(DW)) u_rtn_cmp (
            .lanes(look_lanes), .lane_ign(bp_ign_q[i]), .data(rtn_data),
            .ref_value(bp_value_q[i]), .val_eq(rtn_eq));

        assign v_on  = ~&bp_ign_q[i];
        assign a_hit = acc_valid &&
            masked_eq(64'(acc_addr), 64'(bp_addr_q[i]), 64'(bp_amask_q[i]));
        assign imm_hit[i] = a_hit && (acc_store
            ? (st_en_q[i] && (!v_on || (!acc_unaligned && acc_eq)))
            : (ld_en_q[i] && !v_on));
        assign arm[i] = a_hit && !acc_store && ld_en_q[i] && v_on;
        assign rtn_match[i] = rtn_valid && !rtn_err && look_valid &&
                              look_bps[i] && rtn_eq;
    end

    dbv_tag_table #(.NUM_BP(NUM_BP), .NB(NB), .IDW(IDW)) u_tags (
        .clk(clk), .rst(rst),
        .alloc_en(acc_valid && !acc_store), .alloc_id(acc_id),
        .alloc_bps(arm), .alloc_lanes(acc_lanes),
        .alloc_imp(acc_nonblk || in_window),
        .look_id(rtn_id), .look_valid(look_valid), .look_bps(look_bps),
        .look_lanes(look_lanes), .look_imp(look_imp),
        .consume_en(rtn_valid), .hit_en(|rtn_match),
        .err_en(lerr_valid), .err_id(lerr_id), .err_broke(err_broke));

    // Status, break and late-error flags
    logic [NUM_BP-1:0] status_q, status_clr;
    logic              brk_pend_q, brk_imp_q, new_brk;
    logic [1:0]        flags_q, flags_clr, flags_set;

    assign status_clr = (cfg_we && sel == SEL_STATUS) ? NUM_BP'(cfg_wdata) : '0;
    assign flags_clr  = (cfg_we && sel == SEL_FLAGS) ? cfg_wdata[1:0] : 2'b00;
    assign flags_set[FLG_BUS]   = lerr_valid && err_broke && !lerr_cache;
    assign flags_set[FLG_CACHE] = lerr_valid && err_broke && lerr_cache;
    assign new_brk = |imm_hit || |rtn_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q   <= '0;
            flags_q    <= 2'b00;
            brk_pend_q <= 1'b0;
            brk_imp_q  <= 1'b0;
        end else begin
            status_q <= (status_q & ~status_clr) | imm_hit | rtn_match;
            flags_q  <= (flags_q & ~flags_clr) | flags_set;
            if (new_brk) begin
                brk_pend_q <= 1'b1;
                brk_imp_q  <= !(|imm_hit) && look_imp;
            end else if (brk_pend_q && !brk_hold) begin
                brk_pend_q <= 1'b0;
            end
        end
    end

    assign bp_status      = status_q;
    assign brk_req        = brk_pend_q && !brk_hold;
    assign brk_imprecise  = brk_pend_q && brk_imp_q;
    assign pend_bus_err   = flags_q[FLG_BUS];
    assign pend_cache_err = flags_q[FLG_CACHE];

    for (genvar i = 0; i < NUM_BP; i++) begin : g_chk
        assert_status_sticky_R9: assert property (@(posedge clk) disable iff (rst)
            (status_q[i] && !status_clr[i]) |=> status_q[i]);
    end

    assert_err_return_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (rtn_valid && rtn_err && !acc_valid && !cfg_we) |=> (status_q == $past(status_q)));

    assert_held_break_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (brk_pend_q && brk_hold) |=> brk_pend_q);

    assert_single_request_R10: assert property (@(posedge clk) disable iff (rst)
        (brk_req && !new_brk) |=> !brk_req);

    assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (flags_q[FLG_BUS] && !flags_clr[FLG_BUS]) |=> flags_q[FLG_BUS]);
endmodule

// File: tb/dbv_unit_bench.sv
`timescale 1ns/1ps
module dbv_unit_bench;
    localparam int NUM_BP = 2, AW = 16, DW = 16, IDW = 2, NB = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_we = 0; logic [0:0] cfg_bp = 0; logic [3:0] cfg_sel = 0; logic [DW-1:0] cfg_wdata = 0;
    logic acc_valid = 0, acc_store = 0, acc_unaligned = 0, acc_nonblk = 0;
    logic [AW-1:0] acc_addr = 0; logic [NB-1:0] acc_lanes = 0; logic [DW-1:0] acc_wdata = 0;
    logic [IDW-1:0] acc_id = 0;
    logic rtn_valid = 0, rtn_err = 0; logic [IDW-1:0] rtn_id = 0; logic [DW-1:0] rtn_data = 0;
    logic lerr_valid = 0, lerr_cache = 0; logic [IDW-1:0] lerr_id = 0;
    logic brk_hold = 0;
    logic [NUM_BP-1:0] bp_status;
    logic brk_req, brk_imprecise, pend_bus_err, pend_cache_err;

    int vecs = 0, errs = 0, cyc = 0;

    always #4 clk = ~clk;

    dbv_unit #(.NUM_BP(NUM_BP), .AW(AW), .DW(DW), .IDW(IDW)) u_dbv_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bp(cfg_bp), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_store(acc_store),
        .acc_unaligned(acc_unaligned), .acc_nonblk(acc_nonblk), .acc_addr(acc_addr),
        .acc_lanes(acc_lanes), .acc_wdata(acc_wdata), .acc_id(acc_id),
        .rtn_valid(rtn_valid), .rtn_id(rtn_id), .rtn_data(rtn_data), .rtn_err(rtn_err),
        .lerr_valid(lerr_valid), .lerr_id(lerr_id), .lerr_cache(lerr_cache),
        .brk_hold(brk_hold), .bp_status(bp_status), .brk_req(brk_req),
        .brk_imprecise(brk_imprecise), .pend_bus_err(pend_bus_err),
        .pend_cache_err(pend_cache_err));

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errs++;
            $display("FAIL watchdog: run did not finish, cycle %0d expected below 50000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int bp, input int sel, input int d);
        @(negedge clk);
        cfg_we = 1; cfg_bp = 1'(bp); cfg_sel = 4'(sel); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic store(input int addr, input int lanes, input int data, input bit unal);
        @(negedge clk);
        acc_valid = 1; acc_store = 1; acc_addr = 16'(addr); acc_lanes = 2'(lanes);
        acc_wdata = 16'(data); acc_unaligned = unal;
        @(negedge clk);
        acc_valid = 0; acc_store = 0; acc_unaligned = 0;
    endtask

    task automatic load(input int addr, input int lanes, input int id, input bit nb);
        @(negedge clk);
        acc_valid = 1; acc_store = 0; acc_addr = 16'(addr); acc_lanes = 2'(lanes);
        acc_id = 2'(id); acc_nonblk = nb;
        @(negedge clk);
        acc_valid = 0; acc_nonblk = 0;
    endtask

    task automatic ret(input int id, input int data, input bit err);
        @(negedge clk);
        rtn_valid = 1; rtn_id = 2'(id); rtn_data = 16'(data); rtn_err = err;
        @(negedge clk);
        rtn_valid = 0; rtn_err = 0;
    endtask

    task automatic lerr(input int id, input bit cache);
        @(negedge clk);
        lerr_valid = 1; lerr_id = 2'(id); lerr_cache = cache;
        @(negedge clk);
        lerr_valid = 0;
    endtask

    task automatic clear_all;
        cfg(0, 7, 3);
        cfg(0, 8, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("reset status", int'(bp_status), 0);
        chk("reset brk_req", int'(brk_req), 0);
        chk("reset flags", int'({pend_cache_err, pend_bus_err}), 0);

        // R2 sweep: store value compare over lanes x ignore x differing bytes
        cfg(0, 0, 16'h1230); cfg(0, 1, 16'h000F); cfg(0, 2, 16'hA55A);
        cfg(1, 3, 0);
        for (int ign = 0; ign < 4; ign++) begin
            cfg(0, 3, 2 | (ign << 2));
            for (int ln = 0; ln < 4; ln++) begin
                for (int df = 0; df < 4; df++) begin
                    int exp;
                    int d;
                    d = 16'hA55A ^ (((df >> 1) & 1) << 8) ^ (df & 1);
                    exp = 1;
                    for (int k = 0; k < 2; k++)
                        if (((ln >> k) & 1) == 1 && ((ign >> k) & 1) == 0 && ((df >> k) & 1) == 1)
                            exp = 0;
                    store(16'h1235, ln, d, 0);
                    chk($sformatf("R2 status ign=%0d ln=%0d df=%0d", ign, ln, df), int'(bp_status), exp);
                    chk($sformatf("R2 brk ign=%0d ln=%0d df=%0d", ign, ln, df), int'(brk_req), exp);
                    cfg(0, 7, 3);
                end
            end
        end

        // R3: unaligned store with equal data
        for (int ign = 0; ign < 4; ign++) begin
            cfg(0, 3, 2 | (ign << 2));
            store(16'h1230, 3, 16'hA55A, 1);
            chk($sformatf("R3 unaligned ign=%0d", ign), int'(bp_status), (ign == 3) ? 1 : 0);
            cfg(0, 7, 3);
        end

        // R1: address mask walk, address-only store slot
        cfg(0, 3, 2 | (3 << 2));
        for (int off = 0; off < 32; off++) begin
            int a;
            int exp;
            a = 16'h1220 + off;
            exp = ((a >> 4) == 16'h123) ? 1 : 0;
            store(a, 3, 0, 0);
            chk($sformatf("R1 addr %0h status", a), int'(bp_status), exp);
            if (exp == 1) chk("R1 precise tag", int'(brk_imprecise), 0);
            cfg(0, 7, 3);
        end

        // R11: load-only slot ignores stores, loads hit by address
        cfg(0, 3, 1 | (3 << 2));
        store(16'h1230, 3, 0, 0);
        chk("R11 store on load-only slot", int'(bp_status), 0);
        load(16'h1230, 3, 0, 0);
        chk("R11/R1 load address hit", int'(bp_status), 1);
        chk("R1 load precise", int'(brk_imprecise), 0);
        cfg(0, 7, 3);

        // R4 / R8: deferred load compare
        cfg(0, 2, 16'hBEEF); cfg(0, 3, 1);
        load(16'h1231, 3, 1, 0);
        chk("R4 no match at access", int'({brk_req, bp_status}), 0);
        ret(1, 16'hBEEF, 0);
        chk("R4 status on return", int'(bp_status), 1);
        chk("R4 brk on return", int'(brk_req), 1);
        chk("R8 blocking precise", int'(brk_imprecise), 0);
        cfg(0, 7, 3);
        load(16'h1231, 3, 2, 1);
        ret(2, 16'hBEEF, 0);
        chk("R8 nonblocking imprecise", int'(brk_imprecise), 1);
        cfg(0, 7, 3);
        load(16'h1231, 3, 3, 0);
        ret(3, 16'hBEEE, 0);
        chk("R4 mismatch no status", int'(bp_status), 0);
        load(16'h1231, 1, 3, 0);
        ret(3, 16'h00EF, 0);
        chk("R4 single-lane match", int'(bp_status), 1);
        cfg(0, 7, 3);

        // R5: error with data
        load(16'h1231, 3, 0, 0);
        ret(0, 16'hBEEF, 1);
        chk("R5 error return silent", int'({brk_req, bp_status}), 0);
        ret(0, 16'hBEEF, 0);
        chk("R5 stale return ignored", int'({brk_req, bp_status}), 0);

        // R8: window forces imprecise
        cfg(0, 1, 16'h00FF);
        cfg(0, 4, 16'h1230); cfg(0, 5, 16'h000F); cfg(0, 6, 1);
        load(16'h1231, 3, 1, 0);
        ret(1, 16'hBEEF, 0);
        chk("R8 window imprecise", int'(brk_imprecise), 1);
        cfg(0, 7, 3);
        load(16'h1240, 3, 1, 0);
        ret(1, 16'hBEEF, 0);
        chk("R8 outside window status", int'(bp_status), 1);
        chk("R8 outside window precise", int'(brk_imprecise), 0);
        cfg(0, 6, 0);
        cfg(0, 7, 3);

        // R6: late errors
        load(16'h1231, 3, 2, 0);
        ret(2, 16'hBEEF, 0);
        cfg(0, 7, 3);
        lerr(2, 0);
        chk("R6 bus flag after break", int'(pend_bus_err), 1);
        chk("R6 no new status", int'(bp_status), 0);
        chk("R6 no new brk", int'(brk_req), 0);
        lerr(2, 1);
        chk("R6 second late error no cache flag", int'(pend_cache_err), 0);
        load(16'h1231, 3, 3, 0);
        ret(3, 16'hBEEF, 0);
        lerr(3, 1);
        chk("R6 cache flag", int'(pend_cache_err), 1);
        cfg(0, 8, 1);
        chk("R9 flag W1C bus", int'({pend_cache_err, pend_bus_err}), 2);
        clear_all();
        load(16'h1231, 3, 1, 0);
        lerr(1, 0);
        chk("R6 pending late error no flag", int'(pend_bus_err), 0);
        ret(1, 16'hBEEF, 0);
        chk("R6 dropped compare no break", int'({brk_req, bp_status}), 0);

        // R7: held break
        cfg(0, 1, 0); cfg(0, 3, 2 | (3 << 2));
        @(negedge clk); brk_hold = 1;
        store(16'h1230, 3, 0, 0);
        chk("R7 status while held", int'(bp_status), 1);
        chk("R7 no brk while held", int'(brk_req), 0);
        repeat (3) @(negedge clk);
        chk("R7 still held", int'(brk_req), 0);
        brk_hold = 0;
        #1;
        chk("R7 released", int'(brk_req), 1);
        @(negedge clk);
        chk("R7 one-shot", int'(brk_req), 0);
        cfg(0, 7, 3);

        // R10 / R9: two slots at once
        cfg(1, 0, 16'h1230); cfg(1, 1, 0); cfg(1, 3, 2 | (3 << 2));
        store(16'h1230, 3, 0, 0);
        chk("R10 both status", int'(bp_status), 3);
        chk("R10 brk", int'(brk_req), 1);
        @(negedge clk);
        chk("R10 single request", int'(brk_req), 0);
        cfg(0, 7, 1);
        chk("R9 status W1C", int'(bp_status), 2);
        cfg(0, 7, 0);
        chk("R9 write 0 keeps", int'(bp_status), 2);

        summary();
        $finish;
    end
endmodule